// File: doc/BRIEF.md
# Memory-Mapped Bidirectional GPIO Bank

This block gives a small processor forty general-purpose I/O lines. They are grouped as five 8-bit ports, A to E. Each port has an output latch and a direction register, and both sit on a byte-addressed register bus with separate read and write strobes. For every pin the block produces a drive value and an output enable. It also brings each pad input in through a two-flop synchroniser. A data-register read returns the live synchronised pad value on lines set as inputs and the latch contents on lines set as outputs, so software can do read-modify-write bit operations without disturbing output lines.

Two event outputs come from the same synchronised inputs. A wake-up request pulses when any line of port A, or lines 0 to 3 of port C, changes level. Port C bit 2 also serves as an edge-triggered external interrupt source. The output latch of port E bit 0 selects which edge triggers it. The interrupt is held in a two-state machine with the states IRQ_IDLE and IRQ_PEND. The transition "set" moves IRQ_IDLE to IRQ_PEND on a qualifying edge. The transition "clear" moves IRQ_PEND to IRQ_IDLE when `irq_clear` is high and no new edge arrives in the same cycle. In every other case the machine holds its state.

Top module: `gpio_bank`

## Requirements
- R1: Pad bit 8*p+b belongs to port p (A=0 … E=0x4) bit b. Port p's data register is at address 0x12+2p and its control register is at 0x13+2p.
- R2: Reset state:
  - every output latch and every control bit is 1, so `pad_out` is all ones;
  - `pad_oe` is 0 except on pins 34–36;
  - `irq_pending` is 0;
  - `bus_rdata` is 0x00.
- R3: A control bit of 0 sets that pin's `pad_oe` to 1, and the pin drives its latch bit. A control bit of 1 sets `pad_oe` to 0.
- R4: A data-register read returns the synchronised pad bit where the control bit is 1 and the latch bit where it is 0. The value appears on `bus_rdata` in the cycle after the strobe and is held until the next read.
- R5: A control-register read returns that register's stored value.
- R6: A write to a data register replaces all 8 latch bits one cycle later. Latches keep their value until they are written again.
- R7: A pad change becomes visible to a read whose strobe is sampled two or more clock edges later. A strobe sampled zero or one edge after the change still returns the old value.
- R8: A level change on pins 0–7 or 16–19 raises `wake_req` for exactly one cycle, two clock edges after the change. Changes on other pins never raise it.
- R9: Pin 18 is the interrupt input. If latch bit 32 is 1, a rising edge sets pending. If it is 0, a falling edge sets pending. The opposite edge has no effect.
- R10: `irq_pending` stays set until `irq_clear` is high. If a new edge arrives in the same cycle as the clear, the block stays pending.
- R11: Pins 34–36 are output-only. Their `pad_oe` is always 1, and a read of them returns the latch whatever their control bits hold.
- R12: A read of an unmapped address returns 0x00. A write to an unmapped address changes no latch and no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 40 | Raw pad levels |
| pad_out | output | 40 | Pad drive values (output latches) |
| pad_oe | output | 40 | Pad output enables |
| wake_req | output | 1 | One-cycle wake-up pulse |
| irq_clear | input | 1 | Clears the pending interrupt |
| irq_pending | output | 1 | Sticky external interrupt flag |

## Verification
The bench configures one port with mixed directions and checks that each read bit comes from the correct source. A design that used the wrong source would return pad levels on output lines, or stale latch bits on input lines. It times reads one and two edges after a pad change to catch a synchroniser that is missing a stage or has one too many. It also toggles the interrupt pin in both directions under both polarity settings, which exposes a design that inverts the edge or ignores the polarity latch. Finally, it issues a clear in the same cycle as a fresh edge, writes to unmapped addresses, and reconfigures the output-only pins, catching a design that loses an interrupt, corrupts a register, or releases those pins.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int           W    = 40,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync,
    output logic [W-1:0] sync_prev
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] stage3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= INIT;
            stage2 <= INIT;
            stage3 <= INIT;
        end else begin
            stage1 <= raw;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign sync      = stage2;
    assign sync_prev = stage3;

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int                PORT_W    = 8,
    parameter logic [PORT_W-1:0] FORCE_OUT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_ctrl,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pad_sync,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] rd_data,
    output logic [PORT_W-1:0] rd_ctrl
);

    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] ctrl_q;
    logic [PORT_W-1:0] is_input;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else if (wr_data) begin
            latch_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '1;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata;
        end
    end

    always_comb begin
        is_input = ctrl_q & ~FORCE_OUT;
        pad_out  = latch_q;
        pad_oe   = ~is_input;
        rd_data  = (is_input & pad_sync) | (~is_input & latch_q);
        rd_ctrl  = ctrl_q;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(pad_out)); // R6

    AST_OE_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((pad_oe | FORCE_OUT) == (~$past(wdata) | FORCE_OUT))); // R3

    AST_FORCED_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & FORCE_OUT) == FORCE_OUT); // R11

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_now,
    input  logic line_prev,
    input  logic rise_sel,
    input  logic irq_clear,
    output logic irq_pending
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       edge_hit;

    always_comb begin
        edge_hit = rise_sel ? (line_now & ~line_prev) : (~line_now & line_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (edge_hit) state_d = IRQ_PEND;
            IRQ_PEND: if (irq_clear && !edge_hit) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_pending = (state_q == IRQ_PEND);
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !irq_clear) |=> irq_pending); // R10

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && irq_clear && !edge_hit) |=> !irq_pending); // R10

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> irq_pending); // R9

    AST_IRQ_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pending && (line_now == line_prev)) |=> !irq_pending); // R9

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int                               NUM_PORTS      = 5,
    parameter int                               PORT_W         = 8,
    parameter int                               ADDR_W         = 8,
    parameter logic [ADDR_W-1:0]                BASE_ADDR      = 8'h12,
    parameter logic [NUM_PORTS*PORT_W-1:0]      WAKE_MASK      = 40'h00_000F_00FF,
    parameter logic [NUM_PORTS*PORT_W-1:0]      FORCE_OUT_MASK = 40'h1C_0000_0000,
    parameter int                               IRQ_PIN        = 18,
    parameter int                               POL_PIN        = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [PORT_W-1:0]           bus_wdata,
    input  logic                        bus_rd,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_out,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    output logic                        wake_req,
    input  logic                        irq_clear,
    output logic                        irq_pending
);

    localparam int NUM_PINS = NUM_PORTS * PORT_W;

    logic [NUM_PINS-1:0]  sync;
    logic [NUM_PINS-1:0]  sync_prev;
    logic [NUM_PORTS-1:0] hit_data;
    logic [NUM_PORTS-1:0] hit_ctrl;
    logic [PORT_W-1:0]    port_rd_data [NUM_PORTS];
    logic [PORT_W-1:0]    port_rd_ctrl [NUM_PORTS];
    logic [PORT_W-1:0]    rd_val;
    logic                 rd_hit;

    gpio_sync #(
        .W    (NUM_PINS),
        .INIT ('1)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (pad_in),
        .sync      (sync),
        .sync_prev (sync_prev)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR + 2 * p);
        localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE_ADDR + 2 * p + 1);

        assign hit_data[p] = (bus_addr == DATA_ADDR);
        assign hit_ctrl[p] = (bus_addr == CTRL_ADDR);

        gpio_port #(
            .PORT_W    (PORT_W),
            .FORCE_OUT (FORCE_OUT_MASK[p*PORT_W +: PORT_W])
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_data  (bus_wr & hit_data[p]),
            .wr_ctrl  (bus_wr & hit_ctrl[p]),
            .wdata    (bus_wdata),
            .pad_sync (sync[p*PORT_W +: PORT_W]),
            .pad_out  (pad_out[p*PORT_W +: PORT_W]),
            .pad_oe   (pad_oe[p*PORT_W +: PORT_W]),
            .rd_data  (port_rd_data[p]),
            .rd_ctrl  (port_rd_ctrl[p])
        );
    end

    always_comb begin
        rd_val = '0;
        rd_hit = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit_data[p]) begin
                rd_val = port_rd_data[p];
                rd_hit = 1'b1;
            end
            if (hit_ctrl[p]) begin
                rd_val = port_rd_ctrl[p];
                rd_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

    assign wake_req = |((sync ^ sync_prev) & WAKE_MASK);

    gpio_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_now    (sync[IRQ_PIN]),
        .line_prev   (sync_prev[IRQ_PIN]),
        .rise_sel    (pad_out[POL_PIN]),
        .irq_clear   (irq_clear),
        .irq_pending (irq_pending)
    );

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rd_hit) |=> (bus_rdata == '0)); // R12

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R4

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !rd_hit) |=> ($stable(pad_out) && $stable(pad_oe))); // R12

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync & WAKE_MASK) == (sync_prev & WAKE_MASK)) |-> !wake_req); // R8

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic [39:0] pad_in;
    logic [39:0] pad_out;
    logic [39:0] pad_oe;
    logic        wake_req;
    logic        irq_clear;
    logic        irq_pending;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .wake_req    (wake_req),
        .irq_clear   (irq_clear),
        .irq_pending (irq_pending)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        tick();
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic test_reset();
        check("R2 pad_out", pad_out, 40'hFF_FFFF_FFFF);
        check("R2 pad_oe", pad_oe, 40'h1C_0000_0000);
        check("R2 irq_pending", {39'd0, irq_pending}, 40'd0);
        check("R2 bus_rdata", {32'd0, bus_rdata}, 40'd0);
    endtask

    task automatic test_ctrl_map();
        logic [7:0] d;
        for (int p = 0; p < 5; p++) begin
            bus_write(8'(8'h13 + 2 * p), 8'(8'h30 + p));
        end
        for (int p = 0; p < 5; p++) begin
            bus_read(8'(8'h13 + 2 * p), d);
            check("R1 R5 ctrl readback", {32'd0, d}, {32'd0, 8'(8'h30 + p)});
        end
        for (int p = 0; p < 5; p++) begin
            bus_write(8'(8'h13 + 2 * p), 8'hFF);
        end
    endtask

    task automatic test_mixed_port();
        logic [7:0] d;
        bus_write(8'h15, 8'h0F);
        bus_write(8'h14, 8'hA5);
        pad_in[15:8] = 8'h3C;
        check("R3 oe port B", {32'd0, pad_oe[15:8]}, 40'hF0);
        check("R6 latch port B", {32'd0, pad_out[15:8]}, 40'hA5);
        tick(); tick(); tick();
        bus_read(8'h14, d);
        check("R4 mixed read", {32'd0, d}, 40'hAC);
        tick(); tick();
        check("R4 rdata held", {32'd0, bus_rdata}, 40'hAC);
        bus_write(8'h15, 8'h00);
        bus_read(8'h14, d);
        check("R4 all-output read", {32'd0, d}, 40'hA5);
        check("R3 oe all output", {32'd0, pad_oe[15:8]}, 40'hFF);
        bus_write(8'h14, 8'h5A);
        tick(); tick(); tick();
        check("R6 latch whole byte", {32'd0, pad_out[15:8]}, 40'h5A);
        bus_write(8'h15, 8'hFF);
        check("R3 oe all input", {32'd0, pad_oe[15:8]}, 40'h00);
        pad_in[15:8] = 8'hFF;
    endtask

    task automatic test_sync_latency();
        logic [7:0] d;
        pad_in[31:24] = 8'h00;
        bus_read(8'h18, d);
        check("R7 zero edges old", {32'd0, d}, 40'hFF);
        bus_read(8'h18, d);
        check("R7 one edge old", {32'd0, d}, 40'hFF);
        bus_read(8'h18, d);
        check("R7 two edges new", {32'd0, d}, 40'h00);
        pad_in[31:24] = 8'hFF;
        tick(); tick();
    endtask

    task automatic test_wake();
        bit seen;
        pad_in[3] = 1'b0;
        tick();
        check("R8 wake early", {39'd0, wake_req}, 40'd0);
        tick();
        check("R8 wake pulse", {39'd0, wake_req}, 40'd1);
        tick();
        check("R8 wake one cycle", {39'd0, wake_req}, 40'd0);
        pad_in[19] = 1'b0;
        tick(); tick();
        check("R8 wake port C bit 3", {39'd0, wake_req}, 40'd1);
        seen = 1'b0;
        pad_in[8]  = 1'b0;
        pad_in[20] = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            if (k > 0 && wake_req) seen = 1'b1;
        end
        check("R8 no wake off-mask", {39'd0, seen}, 40'd0);
        pad_in[3] = 1'b1; pad_in[19] = 1'b1; pad_in[8] = 1'b1; pad_in[20] = 1'b1;
        tick(); tick(); tick();
    endtask

    task automatic test_irq();
        pad_in[18] = 1'b0;
        tick(); tick(); tick(); tick();
        check("R9 falling ignored when rise", {39'd0, irq_pending}, 40'd0);
        pad_in[18] = 1'b1;
        tick(); tick();
        check("R9 not yet pending", {39'd0, irq_pending}, 40'd0);
        tick();
        check("R9 rising sets", {39'd0, irq_pending}, 40'd1);
        tick(); tick();
        check("R10 sticky", {39'd0, irq_pending}, 40'd1);
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
        check("R10 cleared", {39'd0, irq_pending}, 40'd0);
        bus_write(8'h1A, 8'hFE);
        check("R9 polarity latch", {39'd0, pad_out[32]}, 40'd0);
        pad_in[18] = 1'b0;
        tick(); tick(); tick();
        check("R9 falling sets", {39'd0, irq_pending}, 40'd1);
        pad_in[18] = 1'b1;
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
        tick(); tick(); tick();
        check("R9 rising ignored when fall", {39'd0, irq_pending}, 40'd0);
        pad_in[18] = 1'b0;
        tick(); tick();
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
        check("R10 set wins over clear", {39'd0, irq_pending}, 40'd1);
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
        check("R10 cleared after", {39'd0, irq_pending}, 40'd0);
        pad_in[18] = 1'b1;
        bus_write(8'h1A, 8'hFF);
        tick(); tick(); tick();
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
    endtask

    task automatic test_forced();
        logic [7:0] d;
        bus_write(8'h1B, 8'h00);
        check("R11 oe all out", {32'd0, pad_oe[39:32]}, 40'hFF);
        bus_write(8'h1B, 8'hFF);
        check("R11 forced oe", {32'd0, pad_oe[39:32]}, 40'h1C);
        pad_in[39:32] = 8'h00;
        tick(); tick(); tick();
        bus_read(8'h1A, d);
        check("R11 forced read latch", {32'd0, d}, 40'h1C);
        pad_in[39:32] = 8'hFF;
        tick(); tick();
    endtask

    task automatic test_unmapped();
        logic [7:0] d;
        logic [39:0] out_before;
        logic [39:0] oe_before;
        out_before = pad_out;
        oe_before  = pad_oe;
        bus_write(8'h11, 8'h00);
        bus_write(8'h1C, 8'h00);
        bus_write(8'h00, 8'h00);
        check("R12 write no latch change", pad_out, out_before);
        check("R12 write no ctrl change", pad_oe, oe_before);
        bus_read(8'h13, d);
        check("R12 ctrl intact", {32'd0, d}, 40'hFF);
        bus_read(8'h1C, d);
        check("R12 unmapped read 0x1C", {32'd0, d}, 40'h00);
        bus_read(8'h13, d);
        bus_read(8'h11, d);
        check("R12 unmapped read 0x11", {32'd0, d}, 40'h00);
    endtask

    initial begin
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        bus_rd    = 1'b0;
        pad_in    = '1;
        irq_clear = 1'b0;
        tick(); tick(); tick();
        test_reset();
        rst_n = 1'b1;
        tick(); tick();
        test_reset();
        test_ctrl_map();
        test_mixed_port();
        test_sync_latency();
        test_wake();
        test_irq();
        test_forced();
        test_unmapped();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule